// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller with Full-Scale Code Remap

This block sequences a successive-approximation conversion. It sends a trial code to an external DAC and reads back one comparator decision per clock. With these it runs a binary search, from the most significant bit down, for the code that matches the held sample. A pulse on `start` begins a conversion. A single-cycle `done` strobe then marks the moment `result` holds the new code.

The block has two modes. In plain mode it returns the usual N-bit search result, and the positive reference lands one code below the top. In full-range mode it runs one extra comparison after the N-bit search, which lets the intermediate code reach 2^N. It then drops the middle code of the scale, so that a zero input reads 0 and an input equal to the reference reads 2^N-1. The price is one code step, just above mid-scale, that is twice as wide as the others.

The result side has no back-pressure. Each accepted `start` produces exactly one `done`. `result` keeps its value until the next `done`, so a consumer may sample it at any time between strobes.

Top module: `sar_ctrl`

## Requirements
- R1: While reset is held and right after it, `done`, `busy`, `track`, `result` and `dac_code` are all zero.
- R2: A `start` seen while idle opens one `track` cycle, followed by N trial cycles (MSB first). `done` rises N+1 clock edges after the edge that sampled `start` in plain mode, and N+2 edges after it in full-range mode.
- R3: In each trial the bit under test is set in the code driven on `dac_code`. The bit is kept only if `cmp_above` is 1, meaning the sample is strictly above the DAC output. A sample equal to the DAC output keeps the lower half.
- R4: In plain mode, `result` is the N-bit search code, and `dac_code` bit N stays 0 throughout the conversion.
- R5: In full-range mode, one extra cycle drives search code z plus 1 on `dac_code`. The intermediate code x is z+1 if `cmp_above` is 1, and z otherwise, so x spans 0 to 2^N. `dac_code` never exceeds 2^N.
- R6: In full-range mode, `result` equals x when x < 2^(N-1), and x-1 when x >= 2^(N-1).
- R7: In full-range mode, a zero input gives 0 and an input equal to the reference gives 2^N-1. The intermediate codes 2^(N-1)-1 and 2^(N-1) both read 2^(N-1)-1.
- R8: `done` is high for exactly one cycle per conversion. `result` does not change except in the cycle `done` is high.
- R9: `start` is accepted only while `busy` is 0. A `start` during a conversion changes neither that conversion nor its mode, and it does not launch another conversion.
- R10: `full_range` is sampled together with an accepted `start` and applies to that conversion only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a conversion; taken only while idle |
| full_range | input | 1 | 1 selects the extra step and the mid-code remap |
| cmp_above | input | 1 | Comparator: 1 when the sample is strictly above the DAC output |
| dac_code | output | N+1 | Trial code sent to the DAC (bit N is used only in full-range mode) |
| track | output | 1 | High for the single sampling cycle |
| busy | output | 1 | High from the sampling cycle until done inclusive |
| done | output | 1 | One-cycle strobe: result is new |
| result | output | N | Converted code |

## Verification
The assertions check, on every cycle, the following properties: the single-cycle `done` pulse, the stability of `result` outside the strobe, the rule that a sampling cycle only follows an accepted idle `start`, the sampling pulse width, and the range of `dac_code` in each mode. Some behaviours need a comparator model driven by a known input, so only the bench scenarios can show them. These are the correctness of the search, the tie rule, the remapped endpoints, the doubled step at mid-scale and the exact done latency in each mode.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_TRIAL,
    ST_EXTRA,
    ST_DONE
  } sar_state_e;
endpackage

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             full_range,
  output sar_state_e       state,
  output logic [IW-1:0]    bit_idx,
  output logic             mode_q,
  output logic             last_step
);
  localparam logic [IW-1:0] TOP_IDX = IW'(N - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_idx <= '0;
      mode_q  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state  <= ST_SAMPLE;
          mode_q <= full_range;
        end
        ST_SAMPLE: begin
          state   <= ST_TRIAL;
          bit_idx <= TOP_IDX;
        end
        ST_TRIAL: begin
          if (bit_idx == '0) state <= mode_q ? ST_EXTRA : ST_DONE;
          else               bit_idx <= bit_idx - 1'b1;
        end
        ST_EXTRA: state <= ST_DONE;
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    last_step = ((state == ST_TRIAL) && (bit_idx == '0) && !mode_q) ||
                (state == ST_EXTRA);
  end
endmodule

// File: rtl/sar_trial.sv
module sar_trial
  import sar_pkg::*;
#(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sar_state_e    state,
  input  logic [IW-1:0] bit_idx,
  input  logic          cmp_above,
  output logic [N:0]    dac_code,
  output logic [N:0]    x_next
);
  logic [N-1:0] code_q;
  logic [N-1:0] bit_sel;
  logic [N-1:0] probe;
  logic [N:0]   code_ext;
  logic [N:0]   code_inc;

  always_comb begin
    bit_sel  = N'(1) << bit_idx;
    probe    = code_q | bit_sel;
    code_ext = {1'b0, code_q};
    code_inc = code_ext + (N+1)'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         code_q <= '0;
    else if (state == ST_SAMPLE)        code_q <= '0;
    else if (state == ST_TRIAL && cmp_above) code_q <= probe;
  end

  always_comb begin
    unique case (state)
      ST_TRIAL: begin
        dac_code = {1'b0, probe};
        x_next   = cmp_above ? {1'b0, probe} : code_ext;
      end
      ST_EXTRA: begin
        dac_code = code_inc;
        x_next   = cmp_above ? code_inc : code_ext;
      end
      default: begin
        dac_code = code_ext;
        x_next   = code_ext;
      end
    endcase
  end
endmodule

// File: rtl/sar_remap.sv
module sar_remap #(
  parameter int N = 8
) (
  input  logic [N:0]   x_code,
  input  logic         full_range,
  output logic [N-1:0] y_code
);
  localparam logic [N:0] HALF = (N+1)'(1) << (N - 1);
  logic [N:0] x_dec;

  always_comb begin
    x_dec = x_code - (N+1)'(1);
    if (full_range && (x_code >= HALF)) y_code = x_dec[N-1:0];
    else                                y_code = x_code[N-1:0];
  end
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         full_range,
  input  logic         cmp_above,
  output logic [N:0]   dac_code,
  output logic         track,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] result
);
  sar_state_e    state;
  logic [IW-1:0] bit_idx;
  logic          mode_q;
  logic          last_step;
  logic [N:0]    x_next;
  logic [N-1:0]  y_next;

  sar_seq #(.N(N)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .full_range(full_range),
    .state(state), .bit_idx(bit_idx), .mode_q(mode_q), .last_step(last_step)
  );

  sar_trial #(.N(N)) u_trial (
    .clk(clk), .rst_n(rst_n), .state(state), .bit_idx(bit_idx),
    .cmp_above(cmp_above), .dac_code(dac_code), .x_next(x_next)
  );

  sar_remap #(.N(N)) u_remap (
    .x_code(x_next), .full_range(mode_q), .y_code(y_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         result <= '0;
    else if (last_step) result <= y_next;
  end

  always_comb begin
    track = (state == ST_SAMPLE);
    busy  = (state != ST_IDLE);
    done  = (state == ST_DONE);
  end
endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [N:0]   dac_code,
  input logic         track,
  input logic         busy,
  input logic         done,
  input logic [N-1:0] result,
  input logic         mode_q
);
  localparam logic [N:0] FULL = (N+1)'(1) << N;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result)); // R8
  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(track) |-> ($past(start) && !$past(busy))); // R9
  AST_TRACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    track |=> (!track && busy)); // R2
  AST_PLAIN_DAC_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mode_q) |-> !dac_code[N]); // R4
  AST_FULL_DAC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    dac_code <= FULL); // R5
endmodule

bind sar_ctrl sar_ctrl_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .dac_code(dac_code),
  .track(track), .busy(busy), .done(done), .result(result), .mode_q(mode_q)
);

// File: tb/sim_sar_ctrl.sv
module sim_sar_ctrl;
  localparam int N   = 8;
  localparam int REF = 2 ** (N + 1);

  typedef struct {
    int    y;
    int    lat;
    int    c0;
    string tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         full_range = 1'b0;
  logic         cmp_above;
  logic [N:0]   dac_code;
  logic         track, busy, done;
  logic [N-1:0] result;

  int vin = 0;
  int cnt = 0;
  int n_checks = 0;
  int n_fail = 0;
  int n_done = 0;
  int n_sent = 0;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cnt <= cnt + 1;

  // analog stand-in: vin in half-LSB units, DAC code c sits at c - 1/2 LSB
  always_comb cmp_above = (vin > 2 * int'(dac_code) - 1);

  sar_ctrl #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .full_range(full_range),
    .cmp_above(cmp_above), .dac_code(dac_code), .track(track),
    .busy(busy), .done(done), .result(result)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_code(input int v, input bit fr);
    int x = v / 2;
    if (!fr) return (x > 2**N - 1) ? 2**N - 1 : x;
    if (x > 2**N) x = 2**N;
    return (x < 2**(N-1)) ? x : x - 1;
  endfunction

  task automatic convert(input int v, input bit fr, input string tag,
                         input bit poke_busy = 1'b0);
    exp_t e;
    @(negedge clk);
    vin = v; full_range = fr; start = 1'b1;
    e.y = expect_code(v, fr); e.lat = fr ? N + 3 : N + 2; e.c0 = cnt; e.tag = tag;
    sb.push_back(e);
    n_sent++;
    @(negedge clk);
    start = 1'b0; full_range = !fr;   // R10: later changes must not matter
    if (poke_busy) begin
      repeat (3) @(negedge clk);
      start = 1'b1;                    // R9: start while busy
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        exp_t e;
        n_done++;
        if (sb.size() == 0) begin
          check(1'b0, "R9 unexpected done", n_done, n_sent);
        end else begin
          e = sb.pop_front();
          check(int'(result) == e.y, e.tag, int'(result), e.y);
          check(cnt - e.c0 == e.lat, "R2 latency", cnt - e.c0, e.lat);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", cnt, 0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [N-1:0] held;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(track == 1'b0, "R1 track", int'(track), 0);
    check(result == '0, "R1 result", int'(result), 0);
    check(dac_code == '0, "R1 dac_code", int'(dac_code), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 1'b0 && result == '0, "R1 after release", int'(result), 0);

    // plain mode
    convert(0,   1'b0, "R4 plain zero");
    convert(REF, 1'b0, "R4 plain reference");
    convert(100, 1'b0, "R4 plain mid");
    convert(101, 1'b0, "R3 tie keeps lower");
    convert(255, 1'b0, "R3 tie below half");

    // full-range mode
    convert(0,   1'b1, "R7 full zero");
    convert(REF, 1'b1, "R7 full reference");
    convert(REF - 2, 1'b1, "R5 extra step not taken");
    convert(254, 1'b1, "R6 below mid");
    convert(256, 1'b1, "R7 mid code skipped");
    convert(258, 1'b1, "R6 above mid");
    convert(1,   1'b1, "R3 tie at bottom");

    // R8: result held after done
    held = result;
    repeat (6) @(negedge clk);
    check(result == held && !done, "R8 result held", int'(result), int'(held));

    // R9/R10: start during conversion with mode flipped
    convert(300, 1'b0, "R9 busy start ignored", 1'b1);
    check(busy == 1'b0, "R9 no second conversion", int'(busy), 0);
    convert(300, 1'b1, "R10 mode latched", 1'b1);
    check(busy == 1'b0, "R9 idle after", int'(busy), 0);

    // sweep
    for (int i = 0; i < 12; i++)
      convert((i * 47) % (REF + 1), i[0], "R6 sweep");

    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R2 one done per start", sb.size(), 0);
    check(n_done == n_sent, "R9 done count", n_done, n_sent);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule